// File: doc/BRIEF.md
# Segment LCD Frame Timing Generator

This block derives the timing for a multiplexed segment LCD from a slow oscillator clock. Three stages are cascaded. A power-of-two prescaler divides the clock by 16, 32, 64 or 128. A programmable divider then divides by one to eight. A common-line phase counter runs through as many phases as the selected duty has common lines. The block produces a one-cycle strobe at each common-line phase, the index of the common line being driven, and a one-cycle strobe once per frame. A frame therefore lasts prescale × divide × common-line-count oscillator cycles. At 32768 Hz with prescale 128, divide 8 and static duty, the frame rate is 32 Hz. With prescale 64, divide 5 and three common lines it is about 34.1 Hz.

The block also reports the largest segment-line count that the active duty leaves free. The settings inputs are copied into an active set only when the block starts or a frame ends, so a frame is never cut short. A two-state controller handles this. `ST_IDLE` holds while enable is low and leaves on transition T_START (enable high), which also loads the active settings. `ST_RUN` holds while enable is high, reloads the settings on transition T_FRAME (the frame strobe), and returns to `ST_IDLE` on transition T_STOP (enable low).

Top module: `lcd_frame_timer`

## Requirements
- R1: During and right after synchronous active-high reset, `com_idx` is 0, both strobes are low and `seg_max` is 44, because the active settings return to prescale 16, divide 1 and static duty.
- R2: While `en` is low, no strobe is produced and `com_idx` is held at 0.
- R3: With `en` high, `com_stb` is high for one cycle every P×D cycles. The first one falls in the P×D-th cycle in which `en` is high.
- R4: The prescale P is 16 << `pre_sel`, so codes 0, 1, 2 and 3 give 16, 32, 64 and 128.
- R5: The divide D is `clk_div` + 1, which ranges from 1 to 8.
- R6: `duty_sel` sets the common-line count N: 0 gives 1 (static), 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 6, and 5, 6 or 7 give 8. `com_idx` advances by one after each `com_stb` and wraps from N−1 to 0.
- R7: `frame_stb` is high exactly with the `com_stb` at which `com_idx` is N−1. A frame therefore lasts P×D×N cycles.
- R8: A change of `pre_sel`, `clk_div` or `duty_sel` while running takes effect only after the next `frame_stb`.
- R9: `seg_max` is 44 for an active duty of 1 to 4 common lines, 42 for 6 and 40 for 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears all counters |
| pre_sel | input | 2 | Prescale select (P = 16 << code) |
| clk_div | input | 3 | Divider field (D = code + 1) |
| duty_sel | input | 3 | Duty select (common-line count) |
| com_stb | output | 1 | One-cycle strobe per common-line phase |
| com_idx | output | 3 | Index of the active common line |
| frame_stb | output | 1 | One-cycle strobe at the end of each frame |
| seg_max | output | 6 | Largest segment-line count for the active duty |

## Verification
The hardest case is a settings change in the middle of a running frame. To hit it, the bench enables with a short configuration and then waits ten cycles. It then writes a longer divider and a six-line duty. It checks that the current frame still ends on the old schedule and that `seg_max` stays at 44 until that frame strobe. After the strobe, the next phase takes the new, longer period and `seg_max` drops to 42. Running the longest configuration for a full frame covers the widest counter values.

// File: rtl/lcd_ft_pkg.sv
package lcd_ft_pkg;

    localparam int PSEL_W = 2;
    localparam int DIV_W  = 3;
    localparam int DUTY_W = 3;
    localparam int COM_W  = 3;
    localparam int SEG_W  = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [DIV_W-1:0]  cdiv;
        logic [DUTY_W-1:0] duty;
    } ft_cfg_t;

    localparam ft_cfg_t CFG_DEFAULT = '{psel: '0, cdiv: '0, duty: '0};

    // Index of the last common line for a duty code
    function automatic logic [COM_W-1:0] com_last(input logic [DUTY_W-1:0] d);
        logic [COM_W-1:0] r;
        unique case (d)
            3'd0:    r = 3'd0;
            3'd1:    r = 3'd1;
            3'd2:    r = 3'd2;
            3'd3:    r = 3'd3;
            3'd4:    r = 3'd5;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

    // Segment lines left over for a duty code
    function automatic logic [SEG_W-1:0] seg_limit(input logic [DUTY_W-1:0] d);
        logic [SEG_W-1:0] r;
        unique case (d)
            3'd0, 3'd1, 3'd2, 3'd3: r = 6'd44;
            3'd4:                   r = 6'd42;
            default:                r = 6'd40;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcd_ft_ctrl.sv
module lcd_ft_ctrl
    import lcd_ft_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    frame_stb,
    input  ft_cfg_t cfg_in,
    output ft_cfg_t cfg_act
);

    run_state_e state_q, state_d;
    logic       load_cfg;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: T_START, T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = en ? ST_RUN  : ST_IDLE;
            ST_RUN:  state_d = en ? ST_RUN  : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: load on T_START or T_FRAME
    always_comb begin
        load_cfg = 1'b0;
        unique case (state_q)
            ST_IDLE: load_cfg = en;
            ST_RUN:  load_cfg = en & frame_stb;
            default: load_cfg = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           cfg_act <= CFG_DEFAULT;
        else if (load_cfg) cfg_act <= cfg_in;
    end

endmodule

// File: rtl/lcd_ft_prescaler.sv
module lcd_ft_prescaler #(
    parameter int BASE_LOG2 = 4,
    parameter int PSEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    localparam int N_SEL = 1 << PSEL_W;
    localparam int CNT_W = BASE_LOG2 + N_SEL - 1;

    logic [CNT_W-1:0] lim [N_SEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_v;

    for (genvar g = 0; g < N_SEL; g++) begin : g_lim
        assign lim[g] = CNT_W'((1 << (BASE_LOG2 + g)) - 1);
    end

    assign top_v = lim[psel];
    assign tick  = en && (cnt_q == top_v);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/lcd_ft_divider.sv
module lcd_ft_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] cdiv,
    output logic             tick_out
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_out = en && tick_in && (cnt_q == cdiv);

    always_ff @(posedge clk) begin
        if (rst || !en)     cnt_q <= '0;
        else if (tick_out)  cnt_q <= '0;
        else if (tick_in)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/lcd_ft_phase.sv
module lcd_ft_phase #(
    parameter int COM_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step,
    input  logic [COM_W-1:0] last,
    output logic [COM_W-1:0] idx,
    output logic             wrap
);

    logic [COM_W-1:0] idx_q;

    assign idx  = idx_q;
    assign wrap = en && step && (idx_q == last);

    always_ff @(posedge clk) begin
        if (rst || !en)  idx_q <= '0;
        else if (wrap)   idx_q <= '0;
        else if (step)   idx_q <= idx_q + 1'b1;
    end

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_ft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PSEL_W-1:0] pre_sel,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DUTY_W-1:0] duty_sel,
    output logic              com_stb,
    output logic [COM_W-1:0]  com_idx,
    output logic              frame_stb,
    output logic [SEG_W-1:0]  seg_max
);

    ft_cfg_t cfg_in, cfg_act;
    logic    pre_tick;

    assign cfg_in = '{psel: pre_sel, cdiv: clk_div, duty: duty_sel};

    lcd_ft_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .frame_stb (frame_stb),
        .cfg_in    (cfg_in),
        .cfg_act   (cfg_act)
    );

    lcd_ft_prescaler #(.BASE_LOG2(4), .PSEL_W(PSEL_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .psel (cfg_act.psel),
        .tick (pre_tick)
    );

    lcd_ft_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick_in  (pre_tick),
        .cdiv     (cfg_act.cdiv),
        .tick_out (com_stb)
    );

    lcd_ft_phase #(.COM_W(COM_W)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .step (com_stb),
        .last (com_last(cfg_act.duty)),
        .idx  (com_idx),
        .wrap (frame_stb)
    );

    assign seg_max = seg_limit(cfg_act.duty);

endmodule

// File: rtl/lcd_frame_timer_chk.sv
module lcd_frame_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       com_stb,
    input logic [2:0] com_idx,
    input logic       frame_stb,
    input logic [5:0] seg_max
);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!com_stb && !frame_stb));

    a_r2_idle_idx: assert property (@(posedge clk) disable iff (rst)
        !en |=> (com_idx == 3'd0));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        com_stb |=> !com_stb);

    a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
        (en && com_stb && !frame_stb) |=> (com_idx == $past(com_idx) + 3'd1));

    a_r6_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !com_stb) |=> $stable(com_idx));

    a_r7_frame_on_com: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> com_stb);

    a_r7_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (com_idx == 3'd0));

    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $past(en, 2) && !$past(rst) && !$past(rst, 2)
         && !$past(frame_stb)) |-> $stable(seg_max));

    a_r9_seg_range: assert property (@(posedge clk) disable iff (rst)
        (seg_max == 6'd44) || (seg_max == 6'd42) || (seg_max == 6'd40));

endmodule

bind lcd_frame_timer lcd_frame_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .com_stb   (com_stb),
    .com_idx   (com_idx),
    .frame_stb (frame_stb),
    .seg_max   (seg_max)
);

// File: tb/lcd_frame_timer_tb.sv
module lcd_frame_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] pre_sel  = '0;
    logic [2:0] clk_div  = '0;
    logic [2:0] duty_sel = '0;
    logic       com_stb, frame_stb;
    logic [2:0] com_idx;
    logic [5:0] seg_max;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lcd_frame_timer u_dut (
        .clk (clk), .rst (rst), .en (en),
        .pre_sel (pre_sel), .clk_div (clk_div), .duty_sel (duty_sel),
        .com_stb (com_stb), .com_idx (com_idx),
        .frame_stb (frame_stb), .seg_max (seg_max)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_n(input int d);
        case (d)
            0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_seg(input int d);
        if (d <= 3) return 44;
        if (d == 4) return 42;
        return 40;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        check(com_idx == 0,  "R1 idx in reset", com_idx, 0);
        check(!com_stb && !frame_stb, "R1 strobes in reset", com_stb + frame_stb, 0);
        check(seg_max == 44, "R1 default duty seg_max", seg_max, 44);
        rst = 1'b0;
        @(negedge clk);
        check(seg_max == 44 && com_idx == 0, "R1 after reset", seg_max, 44);
    endtask

    // R2: disabled block stays quiet
    task automatic t_idle();
        int hits = 0;
        en = 1'b0; pre_sel = 2'd0; clk_div = 3'd0; duty_sel = 3'd1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (com_stb || frame_stb || com_idx != 0) hits++;
        end
        check(hits == 0, "R2 no activity with en low", hits, 0);
    endtask

    // R3..R7, R9: one full frame for a configuration
    task automatic t_frame(input int ps, input int cd, input int du);
        int p = 16 << ps;
        int d = cd + 1;
        int n = exp_n(du);
        int pd = p * d;
        int len = pd * n;
        int first_com = -1, n_com = 0, n_frame = 0, bad_pos = 0, bad_idx = 0;
        int bad_act = 0, bad_exp = 0;
        en = 1'b0;
        repeat (2) @(negedge clk);
        pre_sel = 2'(ps); clk_div = 3'(cd); duty_sel = 3'(du);
        en = 1'b1;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (com_stb) begin
                n_com++;
                if (first_com < 0) first_com = k;
            end
            if (frame_stb) n_frame++;
            if (com_stb != ((k % pd) == pd - 1) || frame_stb != ((k % len) == len - 1))
                bad_pos++;
            if (com_idx != (k / pd) % n) begin
                if (bad_idx == 0) begin bad_act = com_idx; bad_exp = (k / pd) % n; end
                bad_idx++;
            end
        end
        check(first_com == pd - 1, $sformatf("R3 R4 R5 first com P=%0d D=%0d", p, d), first_com, pd - 1);
        check(n_com == n, $sformatf("R6 com count duty=%0d", du), n_com, n);
        check(n_frame == 1, $sformatf("R7 frame count len=%0d", len), n_frame, 1);
        check(bad_pos == 0, "R3 R7 strobe positions", bad_pos, 0);
        check(bad_idx == 0, "R6 com_idx sequence", bad_act, bad_exp);
        check(seg_max == exp_seg(du), $sformatf("R9 seg_max duty=%0d", du), seg_max, exp_seg(du));
    endtask

    // R8: mid-frame change waits for the frame boundary
    task automatic t_shadow();
        int k = 0, frame_at = -1, next_com = -1;
        bit seg_early = 1'b0;
        en = 1'b0;
        repeat (2) @(negedge clk);
        pre_sel = 2'd0; clk_div = 3'd0; duty_sel = 3'd1;   // frame 32
        en = 1'b1;
        while (k < 200) begin
            @(negedge clk);
            k++;
            if (k == 10) begin clk_div = 3'd1; duty_sel = 3'd4; end
            if (frame_at < 0 && seg_max != 44) seg_early = 1'b1;
            if (frame_stb && frame_at < 0) frame_at = k;
            else if (com_stb && frame_at >= 0 && next_com < 0) next_com = k;
        end
        check(frame_at == 31, "R8 first frame keeps old length", frame_at, 31);
        check(!seg_early, "R8 seg_max unchanged mid-frame", seg_early, 0);
        check(next_com == 63, "R8 new period after frame", next_com, 63);
        check(seg_max == 42, "R8 R9 new duty applied", seg_max, 42);
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_frame(0, 0, 0);
        t_frame(1, 2, 2);
        t_frame(2, 4, 2);
        t_frame(2, 4, 4);
        t_frame(0, 3, 6);
        t_frame(0, 1, 7);
        t_frame(0, 0, 1);
        t_frame(1, 0, 3);
        t_frame(3, 7, 5);
        t_shadow();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule